// File: doc/BRIEF.md
# Doorbell Command Mailbox Controller

This block is the host-facing register window of a device command mailbox. Host software loads a command word and an input payload through a simple byte-addressed read/write port, then rings a doorbell bit in the control register. The controller snapshots the command, streams the input payload out to a command executor one 64-bit word at a time, and wipes the payload buffer. It then pulses a start strobe and waits for the executor's done handshake. The handshake carries a return code, an output length and a background flag.

On completion the controller rewrites the command register with the output length, loads the status register and drops the doorbell. Software polls that bit to learn that the response, now in the payload buffer, is ready. A separate read-only register reflects the progress of a background operation, which the executor side reports on dedicated inputs. Commands whose input length exceeds the buffer are rejected at once, without reaching the executor.

Top module: `mbx_doorbell_ctrl`

## Requirements
- R1: After reset the 32-bit capability register at byte offset 0x00 reads payload-size exponent 11 in bits [4:0] and message number 9 in bits [10:7], all other bits 0 (value 0x48B).
- R2: The payload buffer starts at byte offset 0x20 and is 2048 bytes. Aligned host writes of 1, 2, 4 or 8 bytes change exactly the addressed bytes.
- R3: Below 0x20, only 4-byte writes to 0x00 (capability) or 0x04 (control) and 8-byte writes to 0x08 (command) take effect. All others, including any write to the status register at 0x10, are ignored.
- R4: The command register holds opcode in bits [7:0], command set in [15:8] and byte length in [36:16]. Writing 1 to control bit 0 while it is 0 latches these fields. It then presents ceil(length/8) payload words in address order on `ex_word_valid`/`ex_word_data`, with `ex_word_last` on the final word. A one-cycle `ex_go` follows, or coincides with the last word, and carries the latched fields.
- R5: When `ex_go` fires, the whole payload buffer becomes zero. Only executor writes made after that point and later host writes appear in it.
- R6: On `ex_done` the status register at 0x10 becomes {return code in [47:32], background flag in bit 0}. The command register becomes {output length, latched set, latched opcode}, and control bit 0 clears on the same edge.
- R7: A status read returns bit 0 as 1 whenever `bg_pct` is nonzero, and the stored flag otherwise.
- R8: The 8-byte register at 0x18 reads `bg_op` in bits [15:0], `bg_pct` in [22:16] and `bg_rc` in [47:32], zero elsewhere.
- R9: While control bit 0 is 1, control and command writes are ignored, so a second doorbell does not start a command. The busy state is readable as control bit 0.
- R10: A doorbell with length above 2048 never raises `ex_go`. It completes within two cycles with return code 0x0002, output length 0 and background flag 0.
- R11: `rdata` is updated on the clock edge that samples `rd_en`. It holds the addressed bytes shifted down to bit 0, with bytes beyond the access size zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 12 | Byte address in the mailbox window |
| size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| wdata | input | 64 | Write data, right-aligned |
| rdata | output | 64 | Read data, right-aligned, registered |
| ex_go | output | 1 | One-cycle command start to the executor |
| ex_set | output | 8 | Latched command set |
| ex_op | output | 8 | Latched opcode |
| ex_len | output | 21 | Latched input length in bytes |
| ex_word_valid | output | 1 | Input payload word valid |
| ex_word_last | output | 1 | Final input payload word |
| ex_word_data | output | 64 | Input payload word |
| ex_out_we | input | 1 | Executor response word write |
| ex_out_idx | input | 8 | Response word index |
| ex_out_data | input | 64 | Response word data |
| ex_done | input | 1 | Executor completion |
| ex_rc | input | 16 | Return code |
| ex_out_len | input | 21 | Output length in bytes |
| ex_bg | input | 1 | Command continues in background |
| bg_op | input | 16 | Background opcode |
| bg_pct | input | 7 | Background percent complete |
| bg_rc | input | 16 | Background return code |

## Verification
The checker assumes that the executor raises `ex_done` only while a command is in flight, after `ex_go`. It also assumes that response words are written only in that window and that a read and a write never share a cycle. The bench's stub responder collects the streamed words, waits a programmable delay, writes the complement of each input word and then signals done for exactly one cycle. The host tasks issue one access at a time, aligned to its size. Busy-window doorbells, ignored register writes, the exact 2048-byte boundary and the oversize rejection are driven as directed cases. Random lengths, sets and payloads fill the rest.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int LEN_W = 21;
    localparam int RC_W  = 16;

    localparam int OFF_CAP  = 0;
    localparam int OFF_CTRL = 4;
    localparam int OFF_CMD  = 8;
    localparam int OFF_STS  = 16;
    localparam int OFF_BGS  = 24;
    localparam int OFF_PL   = 32;

    localparam logic [RC_W-1:0] RC_BAD_LEN = 16'h0002;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_RUN, SQ_FIN} sq_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic [7:0]       cset;
        logic [7:0]       opc;
    } cmd_fields_t;

    typedef struct packed {
        logic [RC_W-1:0] rc;
        logic            bg;
    } sts_fields_t;

    function automatic logic [63:0] cmd_word(cmd_fields_t c);
        return {{(64 - $bits(cmd_fields_t)){1'b0}}, c};
    endfunction

    function automatic logic [63:0] sts_word(sts_fields_t s, logic force_bg);
        return {16'd0, s.rc, 31'd0, s.bg | force_bg};
    endfunction

    function automatic logic [7:0] size_mask(logic [3:0] sz);
        case (sz)
            4'd1:    return 8'h01;
            4'd2:    return 8'h03;
            4'd4:    return 8'h0F;
            4'd8:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic size_legal(logic [3:0] sz);
        return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
    endfunction
endpackage

// File: rtl/mbx_payload_buf.sv
module mbx_payload_buf #(
    parameter  int WORDS = 256,
    localparam int IW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [7:0]    h_be,
    input  logic [63:0]   h_data,
    input  logic          x_we,
    input  logic [IW-1:0] x_idx,
    input  logic [63:0]   x_data,
    input  logic [IW-1:0] a_idx,
    output logic [63:0]   a_data,
    input  logic [IW-1:0] b_idx,
    output logic [63:0]   b_data
);
    logic [63:0]      mem [WORDS];
    logic [WORDS-1:0] vld;
    logic [63:0]      h_base;
    logic [63:0]      h_merged;

    // bytes not being written keep their value unless the word is (or is being) wiped
    always_comb begin
        h_base = (vld[h_idx] && !clr) ? mem[h_idx] : 64'd0;
        for (int b = 0; b < 8; b++) begin
            h_merged[b*8 +: 8] = h_be[b] ? h_data[b*8 +: 8] : h_base[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (clr)  vld <= '0;
            if (x_we) vld[x_idx] <= 1'b1;
            if (h_we) vld[h_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (x_we) mem[x_idx] <= x_data;
        if (h_we) mem[h_idx] <= h_merged;
    end

    assign a_data = vld[a_idx] ? mem[a_idx] : 64'd0;
    assign b_data = vld[b_idx] ? mem[b_idx] : 64'd0;
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter  int PL_LOG2 = 11,
    parameter  int MSG_NUM = 9,
    localparam int PL_BYTES = 1 << PL_LOG2,
    localparam int IW      = PL_LOG2 - 3,
    localparam int CNT_W   = IW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cap,
    input  logic             wr_ctrl,
    input  logic             wr_cmd,
    input  logic [31:0]      w_lo,
    input  cmd_fields_t      w_cmd,
    input  logic             ex_done,
    input  logic [RC_W-1:0]  ex_rc,
    input  logic [LEN_W-1:0] ex_out_len,
    input  logic             ex_bg,
    output sq_state_t        st,
    output logic             db,
    output logic [31:0]      cap_q,
    output cmd_fields_t      cmd_q,
    output sts_fields_t      sts_q,
    output cmd_fields_t      lat,
    output logic [IW-1:0]    send_idx,
    output logic             word_valid,
    output logic             word_last,
    output logic             go
);
    localparam logic [31:0] CAP_RST = {21'd0, 4'(MSG_NUM), 2'd0, 5'(PL_LOG2)};

    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] nw;
    logic [LEN_W-1:0] nw_full;
    logic             oversize;
    cmd_fields_t      done_cmd;
    cmd_fields_t      rej_cmd;

    always_comb begin
        nw_full    = (lat.len + LEN_W'(7)) >> 3;
        nw         = CNT_W'(nw_full);
        go         = (st == SQ_SEND) && ((nw == '0) || (cur == nw - 1'b1));
        word_valid = (st == SQ_SEND) && (nw != '0);
        word_last  = go && word_valid;
        send_idx   = cur[IW-1:0];
        oversize   = cmd_q.len > LEN_W'(PL_BYTES);
        done_cmd   = '{len: ex_out_len, cset: lat.cset, opc: lat.opc};
        rej_cmd    = '{len: '0, cset: lat.cset, opc: lat.opc};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            db    <= 1'b0;
            cap_q <= CAP_RST;
            cmd_q <= '0;
            sts_q <= '0;
            lat   <= '0;
            cur   <= '0;
        end else begin
            if (wr_cap) cap_q <= w_lo;
            unique case (st)
                SQ_IDLE: begin
                    if (wr_cmd) cmd_q <= w_cmd;
                    if (wr_ctrl && w_lo[0]) begin
                        db  <= 1'b1;
                        lat <= cmd_q;
                        cur <= '0;
                        st  <= oversize ? SQ_FIN : SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    cur <= cur + 1'b1;
                    if (go) st <= SQ_RUN;
                end
                SQ_RUN: begin
                    if (ex_done) begin
                        sts_q <= '{rc: ex_rc, bg: ex_bg};
                        cmd_q <= done_cmd;
                        db    <= 1'b0;
                        st    <= SQ_IDLE;
                    end
                end
                SQ_FIN: begin
                    sts_q <= '{rc: RC_BAD_LEN, bg: 1'b0};
                    cmd_q <= rej_cmd;
                    db    <= 1'b0;
                    st    <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_rd_fmt.sv
module mbx_rd_fmt
    import mbx_pkg::*;
(
    input  logic [2:0]  lane,
    input  logic [3:0]  size,
    input  logic [63:0] word,
    output logic [63:0] data
);
    logic [63:0] shifted;
    logic [7:0]  keep;

    always_comb begin
        shifted = word >> {lane, 3'b000};
        keep    = size_mask(size);
        for (int b = 0; b < 8; b++) begin
            data[b*8 +: 8] = keep[b] ? shifted[b*8 +: 8] : 8'd0;
        end
    end
endmodule

// File: rtl/mbx_doorbell_ctrl.sv
module mbx_doorbell_ctrl
    import mbx_pkg::*;
#(
    parameter  int PL_LOG2 = 11,
    parameter  int MSG_NUM = 9,
    localparam int PL_WORDS = (1 << PL_LOG2) / 8,
    localparam int IW       = PL_LOG2 - 3,
    localparam int AW       = PL_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [3:0]       size,
    input  logic [63:0]      wdata,
    output logic [63:0]      rdata,
    output logic             ex_go,
    output logic [7:0]       ex_set,
    output logic [7:0]       ex_op,
    output logic [LEN_W-1:0] ex_len,
    output logic             ex_word_valid,
    output logic             ex_word_last,
    output logic [63:0]      ex_word_data,
    input  logic             ex_out_we,
    input  logic [IW-1:0]    ex_out_idx,
    input  logic [63:0]      ex_out_data,
    input  logic             ex_done,
    input  logic [RC_W-1:0]  ex_rc,
    input  logic [LEN_W-1:0] ex_out_len,
    input  logic             ex_bg,
    input  logic [15:0]      bg_op,
    input  logic [6:0]       bg_pct,
    input  logic [RC_W-1:0]  bg_rc
);
    logic            in_pl;
    logic [IW+2:0]   pl_off;
    logic [2:0]      lane;
    logic [IW-1:0]   pl_idx;
    logic            h_we;
    logic [7:0]      h_be;
    logic [63:0]     h_data;
    logic            wr_cap, wr_ctrl, wr_cmd;
    logic            x_we;
    logic [63:0]     pl_rd;
    logic [63:0]     rd_word;
    logic [63:0]     rd_fmt;
    logic [63:0]     bgs_word;

    sq_state_t       st;
    logic            db;
    logic [31:0]     cap_q;
    cmd_fields_t     cmd_q;
    sts_fields_t     sts_q;
    cmd_fields_t     lat;
    logic [IW-1:0]   send_idx;
    logic            pl_clr;

    // host address decode
    always_comb begin
        in_pl   = addr >= AW'(OFF_PL);
        pl_off  = (IW+3)'(addr - AW'(OFF_PL));
        lane    = pl_off[2:0];
        pl_idx  = pl_off[IW+2:3];
        h_we    = wr_en && in_pl && size_legal(size);
        h_be    = size_mask(size) << lane;
        h_data  = wdata << {lane, 3'b000};
        wr_cap  = wr_en && (addr == AW'(OFF_CAP))  && (size == 4'd4);
        wr_ctrl = wr_en && (addr == AW'(OFF_CTRL)) && (size == 4'd4);
        wr_cmd  = wr_en && (addr == AW'(OFF_CMD))  && (size == 4'd8);
        x_we    = ex_out_we && (st == SQ_RUN);
    end

    mbx_seq #(.PL_LOG2(PL_LOG2), .MSG_NUM(MSG_NUM)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_cap     (wr_cap),
        .wr_ctrl    (wr_ctrl),
        .wr_cmd     (wr_cmd),
        .w_lo       (wdata[31:0]),
        .w_cmd      (cmd_fields_t'(wdata[$bits(cmd_fields_t)-1:0])),
        .ex_done    (ex_done),
        .ex_rc      (ex_rc),
        .ex_out_len (ex_out_len),
        .ex_bg      (ex_bg),
        .st         (st),
        .db         (db),
        .cap_q      (cap_q),
        .cmd_q      (cmd_q),
        .sts_q      (sts_q),
        .lat        (lat),
        .send_idx   (send_idx),
        .word_valid (ex_word_valid),
        .word_last  (ex_word_last),
        .go         (ex_go)
    );

    assign pl_clr = ex_go;
    assign ex_set = lat.cset;
    assign ex_op  = lat.opc;
    assign ex_len = lat.len;

    mbx_payload_buf #(.WORDS(PL_WORDS)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .clr    (pl_clr),
        .h_we   (h_we),
        .h_idx  (pl_idx),
        .h_be   (h_be),
        .h_data (h_data),
        .x_we   (x_we),
        .x_idx  (ex_out_idx),
        .x_data (ex_out_data),
        .a_idx  (pl_idx),
        .a_data (pl_rd),
        .b_idx  (send_idx),
        .b_data (ex_word_data)
    );

    // read word selection
    always_comb begin
        bgs_word = {16'd0, bg_rc, 9'd0, bg_pct, bg_op};
        if (in_pl) begin
            rd_word = pl_rd;
        end else begin
            unique case (addr[4:3])
                2'd0:    rd_word = {31'd0, db, cap_q};
                2'd1:    rd_word = cmd_word(cmd_q);
                2'd2:    rd_word = sts_word(sts_q, bg_pct != 7'd0);
                default: rd_word = bgs_word;
            endcase
        end
    end

    mbx_rd_fmt u_fmt (
        .lane (lane),
        .size (size),
        .word (rd_word),
        .data (rd_fmt)
    );

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_fmt;
    end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk
    import mbx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input sq_state_t   st,
    input logic        db,
    input logic        ex_go,
    input logic        ex_word_valid,
    input logic        ex_done,
    input sts_fields_t sts_q
);
    logic finishing;
    assign finishing = (st == SQ_FIN) || ((st == SQ_RUN) && ex_done);

    // R4: the executor is only started while the doorbell is held
    a_r4_go_under_doorbell: assert property (@(posedge clk) disable iff (rst)
        ex_go |-> db);

    // R4: payload words stream back to back until the start strobe
    a_r4_stream_contiguous: assert property (@(posedge clk) disable iff (rst)
        (ex_word_valid && !ex_go) |=> ex_word_valid);

    // R6: completion drops the doorbell on the same edge
    a_r6_done_clears_doorbell: assert property (@(posedge clk) disable iff (rst)
        ((st == SQ_RUN) && ex_done) |=> (!db && (st == SQ_IDLE)));

    // R9: the doorbell stays set until a completion path is taken
    a_r9_doorbell_held: assert property (@(posedge clk) disable iff (rst)
        (db && !finishing) |=> db);

    // R3: status changes only through completion, never from the host
    a_r3_status_host_immune: assert property (@(posedge clk) disable iff (rst)
        !finishing |=> $stable(sts_q));

    // R10: a rejected command never starts the executor
    a_r10_reject_no_go: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_FIN) |-> (!ex_go && !ex_word_valid));
endmodule

bind mbx_doorbell_ctrl mbx_doorbell_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .st            (st),
    .db            (db),
    .ex_go         (ex_go),
    .ex_word_valid (ex_word_valid),
    .ex_done       (ex_done),
    .sts_q         (sts_q)
);

// File: tb/sim_mbx_doorbell_ctrl.sv
`timescale 1ns/1ps
module sim_mbx_doorbell_ctrl;
    localparam int AW = 12;
    localparam int IW = 8;
    localparam int LW = 21;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    size = 4'd8;
    logic [63:0]   wdata = '0;
    logic [63:0]   rdata;
    logic          ex_go, ex_word_valid, ex_word_last;
    logic [7:0]    ex_set, ex_op;
    logic [LW-1:0] ex_len;
    logic [63:0]   ex_word_data;
    logic          ex_out_we = 1'b0;
    logic [IW-1:0] ex_out_idx = '0;
    logic [63:0]   ex_out_data = '0;
    logic          ex_done = 1'b0;
    logic [15:0]   ex_rc = '0;
    logic [LW-1:0] ex_out_len = '0;
    logic          ex_bg = 1'b0;
    logic [15:0]   bg_op = '0;
    logic [6:0]    bg_pct = '0;
    logic [15:0]   bg_rc = '0;

    always #4 clk = ~clk;

    mbx_doorbell_ctrl u0 (.*);

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input int sz, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); size = 4'(sz); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input int a, input int sz, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = AW'(a); size = 4'(sz);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] v;
        int k = 0;
        do begin
            host_rd(4, 4, v);
            k++;
        end while (v[0] && k < 5000);
    endtask

    // ---------------- stub executor ----------------
    logic [63:0] got_w [256];
    int          got_n = 0, last_got = 0, go_cnt = 0, stub_delay = 4;
    logic [7:0]  go_set, go_op;
    logic [LW-1:0] go_len;
    bit          last_flag_ok = 1'b1;

    initial begin
        forever begin
            @(negedge clk);
            if (ex_word_valid) begin
                got_w[got_n] = ex_word_data;
                got_n++;
            end
            if (ex_go) begin
                int nw;
                go_cnt++;
                go_set = ex_set; go_op = ex_op; go_len = ex_len;
                nw = (int'(go_len) + 7) / 8;
                if (nw != 0 && !ex_word_last) last_flag_ok = 1'b0;
                repeat (stub_delay) @(negedge clk);
                for (int i = 0; i < nw; i++) begin
                    ex_out_we = 1'b1; ex_out_idx = IW'(i); ex_out_data = ~got_w[i];
                    @(negedge clk);
                end
                ex_out_we = 1'b0;
                ex_done = 1'b1; ex_rc = {8'h00, go_op ^ go_set};
                ex_out_len = go_len; ex_bg = go_op[0];
                @(negedge clk);
                ex_done = 1'b0;
                last_got = got_n;
                got_n = 0;
            end
        end
    end

    // ---------------- expected-value helpers ----------------
    function automatic logic [63:0] cmd_val(logic [7:0] s, logic [7:0] o, logic [LW-1:0] l);
        return {27'd0, l, s, o};
    endfunction
    function automatic logic [63:0] sts_val(logic [15:0] rc, logic bg);
        return {16'd0, rc, 31'd0, bg};
    endfunction

    logic [63:0] in_w [256];

    task automatic run_cmd(input logic [7:0] s, input logic [7:0] o, input int len);
        int nw = (len + 7) / 8;
        for (int i = 0; i < nw && i < 256; i++) host_wr(32 + 8*i, 8, in_w[i]);
        host_wr(8, 8, cmd_val(s, o, LW'(len)));
        host_wr(4, 4, 64'd1);
        wait_idle();
    endtask

    task automatic check_result(input string tag, input logic [7:0] s, input logic [7:0] o, input int len);
        logic [63:0] v;
        int nw = (len + 7) / 8;
        chk({tag, " R4 go set"}, 64'(go_set), 64'(s));
        chk({tag, " R4 go op"}, 64'(go_op), 64'(o));
        chk({tag, " R4 go len"}, 64'(go_len), 64'(len));
        chk({tag, " R4 word count"}, 64'(last_got), 64'(nw));
        for (int i = 0; i < nw; i++) chk({tag, " R4 streamed word"}, got_w[i], in_w[i]);
        host_rd(8, 8, v);
        chk({tag, " R6 command"}, v, cmd_val(s, o, LW'(len)));
        host_rd(16, 8, v);
        chk({tag, " R6 status"}, v, sts_val({8'h00, o ^ s}, o[0]));
        for (int i = 0; i < nw + 2 && i < 256; i++) begin
            host_rd(32 + 8*i, 8, v);
            chk({tag, " R5 payload"}, v, (i < nw) ? ~in_w[i] : 64'd0);
        end
    endtask

    initial begin
        logic [63:0] v;
        int g0, len;
        logic [7:0] s, o;
        void'($urandom(32'h5eed_0a17));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 / R11
        host_rd(0, 4, v); chk("R1 capability", v, 64'h48B);
        host_rd(0, 1, v); chk("R11 byte read of capability", v, 64'h8B);
        host_rd(4, 4, v); chk("R9 control idle after reset", v, 64'd0);
        host_rd(16, 8, v); chk("R6 status reset", v, 64'd0);

        // R2 / R11 byte-granular payload
        host_wr(32 + 40, 8, 64'h1122334455667788);
        host_wr(32 + 43, 1, 64'h5C);
        host_wr(32 + 46, 2, 64'hBEEF);
        host_rd(32 + 40, 8, v); chk("R2 merged payload word", v, 64'hBEEF33445C667788);
        host_rd(32 + 42, 2, v); chk("R11 two-byte payload read", v, 64'h5C66);

        // R3 ignored writes
        host_wr(8, 4, 64'hFFFF_FFFF);
        host_rd(8, 8, v); chk("R3 32-bit command write ignored", v, 64'd0);
        host_wr(16, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        host_rd(16, 8, v); chk("R3 status write ignored", v, 64'd0);
        g0 = go_cnt;
        host_wr(4, 2, 64'd1);
        repeat (8) @(negedge clk);
        host_rd(4, 4, v); chk("R3 16-bit control write ignored", v, 64'd0);
        chk("R3 no start from narrow doorbell", 64'(go_cnt), 64'(g0));
        host_wr(0, 4, 64'h0000_048C);
        host_rd(0, 4, v); chk("R3 capability write accepted", v, 64'h48C);
        host_wr(0, 4, 64'h0000_048B);

        // R4 R5 R6 directed with partial last word; stale word 100 must clear
        host_wr(32 + 800, 8, 64'hDEAD_BEEF_0000_1111);
        for (int i = 0; i < 3; i++) in_w[i] = 64'hA5A5_0000_0000_0000 | 64'(i * 7 + 1);
        run_cmd(8'h12, 8'h34, 20);
        check_result("dir20", 8'h12, 8'h34, 20);
        chk("R4 last flag on final word", 64'(last_flag_ok), 64'd1);
        host_rd(32 + 800, 8, v); chk("R5 distant word wiped", v, 64'd0);
        host_rd(32 + 40, 8, v); chk("R5 earlier host word wiped", v, 64'd0);

        // R7 / R8
        bg_op = 16'h0ABC; bg_pct = 7'd40; bg_rc = 16'h0007;
        host_rd(16, 8, v); chk("R7 background bit forced", v, sts_val(16'h0026, 1'b1));
        host_rd(24, 8, v); chk("R8 background status", v, {16'd0, 16'h0007, 9'd0, 7'd40, 16'h0ABC});
        bg_pct = 7'd0;
        host_rd(16, 8, v); chk("R7 stored bit when idle progress", v, sts_val(16'h0026, 1'b0));

        // R9 busy doorbell
        stub_delay = 30;
        in_w[0] = 64'h0102_0304_0506_0708;
        g0 = go_cnt;
        host_wr(32, 8, in_w[0]);
        host_wr(8, 8, cmd_val(8'h01, 8'h03, 21'd8));
        host_wr(4, 4, 64'd1);
        repeat (4) @(negedge clk);
        host_rd(4, 4, v); chk("R9 busy visible", v, 64'd1);
        host_wr(8, 8, cmd_val(8'h09, 8'h09, 21'd16));
        host_wr(4, 4, 64'd1);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R9 single start", 64'(go_cnt), 64'(g0 + 1));
        host_rd(8, 8, v); chk("R9 busy command write ignored", v, cmd_val(8'h01, 8'h03, 21'd8));
        host_rd(16, 8, v); chk("R9 status of first command", v, sts_val(16'h0002, 1'b1));
        stub_delay = 4;

        // R10 oversize rejection
        g0 = go_cnt;
        host_wr(8, 8, cmd_val(8'h44, 8'h55, 21'd2049));
        host_wr(4, 4, 64'd1);
        host_rd(4, 4, v); chk("R10 rejected within two cycles", v, 64'd0);
        repeat (10) @(negedge clk);
        chk("R10 executor not started", 64'(go_cnt), 64'(g0));
        host_rd(16, 8, v); chk("R10 status", v, sts_val(16'h0002, 1'b0));
        host_rd(8, 8, v); chk("R10 command length zero", v, cmd_val(8'h44, 8'h55, 21'd0));

        // R4 boundary: exactly the buffer size
        for (int i = 0; i < 256; i++) in_w[i] = {32'(i), 32'(i) ^ 32'h3C3C_C3C3};
        g0 = go_cnt;
        run_cmd(8'h02, 8'h10, 2048);
        chk("R10 full-size length accepted", 64'(go_cnt), 64'(g0 + 1));
        check_result("full", 8'h02, 8'h10, 2048);

        // R4 zero length
        run_cmd(8'h07, 8'h21, 0);
        check_result("len0", 8'h07, 8'h21, 0);

        // random commands
        for (int n = 0; n < 12; n++) begin
            len = $urandom_range(0, 72);
            s = 8'($urandom); o = 8'($urandom);
            for (int i = 0; i < 10; i++) in_w[i] = {$urandom, $urandom};
            run_cmd(s, o, len);
            check_result("rand", s, o, len);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule